// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked system read and write an unclocked static RAM of 65,536 four-bit words. On the system side a request is offered with `req_valid` and taken on a rising clock edge when `req_ready` is high. Each request carries a 16-bit word address, a direction flag and, for writes, a 4-bit nibble. Read results come back on `rd_data` with a one-cycle `rd_valid` pulse.

On the memory side the controller drives the address, an active-low chip enable and an active-low write enable. The shared 4-bit data bus appears as three signals: the value to drive, a driver enable and the value sampled from the bus. All strobes come from registers.

Every memory timing figure is a nanosecond parameter. Each is converted to a whole number of clock cycles by rounding up against the clock period parameter. With the defaults, a 10 ns clock gives two access cycles for a read and two write-enable-low cycles for a write. A one-cycle setup precedes the write strobe and a one-cycle recovery follows it.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with no request pending, `mem_ce_n`=1, `mem_we_n`=1, `mem_dq_oe`=0 and `rd_valid`=0. Once the release has passed through synchronisation, `req_ready`=1.
- R2: The strobe encoding is: `mem_ce_n`=1 is standby, `mem_ce_n`=0 with `mem_we_n`=1 is a memory read, and both low is a write. In standby, `mem_we_n` is always 1 and `mem_dq_oe` is always 0.
- R3: `mem_addr` holds one value from the cycle before `mem_we_n` falls until the cycle after it rises.
- R4: A write is sequenced as follows. First comes one cycle with `mem_ce_n`=0 and `mem_we_n`=1. Then `mem_we_n` stays 0 for exactly STB cycles (2 by default). Finally `mem_we_n` and `mem_ce_n` rise on the same edge.
- R5: `mem_dq_oe` is 1 only while both strobes are low. It stays 0 for the first WZ cycles of the strobe, where WZ is 1 by default.
- R6: `mem_dq_oe` falls on the same edge where `mem_we_n` rises. While the driver is on, `mem_dq_out` carries the nibble of the accepted write.
- R7: A read holds `mem_ce_n`=0 and `mem_we_n`=1 for RD cycles (2 by default). The bus is sampled on the edge that ends the last of those cycles. `rd_data` and a one-cycle `rd_valid` pulse appear RD edges after the accepting edge.
- R8: After a read, chip enable is high in the cycle in which `rd_valid` is 1. This makes at least one idle cycle before the next access. The driver is never on while the memory is in read mode.
- R9: A request is taken on an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 for the whole access, including the write recovery cycle. It returns STB+3 cycles after a write is accepted and RD+1 cycles after a read is accepted.
- R10: A read returns the nibble most recently written to that address through the controller.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 4 | Write nibble |
| req_ready | output | 1 | Controller can take a request |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 4 | Captured read nibble |
| mem_addr | output | 16 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 4 | Value to drive onto the data bus |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_in | input | 4 | Value sampled from the data bus |

## Verification
The hardest case to reach is a read whose captured value is correct only because the controller waits out the full access count. The case is harder still when the read comes straight after a write to the same address, or straight before one. The bench memory model returns the inverted nibble until the read has lasted the access time, so capturing early shows up as a mismatch. Directed sequences write and then read a single address, read and then write the same address, and write twice before reading. Random traffic is confined to a few addresses so that read-after-write hits are frequent.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSETUP,
    ST_WSTROBE,
    ST_WRECOVER
  } seq_state_e;

  // Round a nanosecond figure up to whole clock cycles
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign zero   = (cnt_q == '0);
  assign cnt    = cnt_q;
  assign cnt_en = load | ~zero;

  always_comb begin
    cnt_d = cnt_q;
    if (load)       cnt_d = load_val;
    else if (!zero) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R7

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] data_q;
  logic              vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= capture;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (capture) data_q <= dq_in;
  end

  assign rd_valid = vld_q;
  assign rd_data  = data_q;

  AST_RDV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R7

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 4,
  parameter int RD_CYC  = 2,
  parameter int STB_CYC = 2,
  parameter int WZ_CYC  = 1,
  parameter int CNT_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  input  logic [CNT_W-1:0]  tmr_cnt,
  input  logic              tmr_zero,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output logic              capture,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);

  localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] STB_LOAD = CNT_W'(STB_CYC - 1);
  localparam logic [CNT_W-1:0] OE_TH    = CNT_W'(STB_CYC - WZ_CYC);
  localparam logic             OE_EARLY = (WZ_CYC == 0);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdat_q;
  logic              ce_n_q, ce_n_d;
  logic              we_n_q, we_n_d;
  logic              oe_q, oe_d;
  logic              accept;
  logic              wdat_en;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready & req_valid;
  assign wdat_en   = accept & req_write;

  // Next-state and strobe decode
  always_comb begin
    state_d  = state_q;
    ce_n_d   = ce_n_q;
    we_n_d   = we_n_q;
    oe_d     = oe_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          ce_n_d = 1'b0;
          if (req_write) begin
            state_d = ST_WSETUP;
          end else begin
            state_d  = ST_READ;
            tmr_load = 1'b1;
            tmr_val  = RD_LOAD;
          end
        end
      end
      ST_READ: begin
        if (tmr_zero) begin
          capture = 1'b1;
          ce_n_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WSETUP: begin
        we_n_d   = 1'b0;
        oe_d     = OE_EARLY;
        tmr_load = 1'b1;
        tmr_val  = STB_LOAD;
        state_d  = ST_WSTROBE;
      end
      ST_WSTROBE: begin
        if (tmr_zero) begin
          we_n_d  = 1'b1;
          ce_n_d  = 1'b1;
          oe_d    = 1'b0;
          state_d = ST_WRECOVER;
        end else begin
          oe_d = (tmr_cnt <= OE_TH);
        end
      end
      ST_WRECOVER: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
        ce_n_d  = 1'b1;
        we_n_d  = 1'b1;
        oe_d    = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ce_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_n_q  <= ce_n_d;
      we_n_q  <= we_n_d;
      oe_q    <= oe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (accept) addr_q <= req_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wdat_q <= '0;
    else if (wdat_en) wdat_q <= req_wdata;
  end

  assign mem_addr   = addr_q;
  assign mem_ce_n   = ce_n_q;
  assign mem_we_n   = we_n_q;
  assign mem_dq_out = wdat_q;
  assign mem_dq_oe  = oe_q;

  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_we_n && !mem_dq_oe)); // R2
  AST_ADDR_HELD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> $stable(mem_addr)); // R3
  AST_ADDR_HELD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> $stable(mem_addr)); // R3
  AST_WE_AFTER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(mem_ce_n) == 1'b0)); // R4
  AST_CE_WE_RISE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_ce_n); // R4
  AST_DRV_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && !mem_ce_n)); // R5
  AST_DRV_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_dq_oe); // R6
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready); // R9

  generate
    if (WZ_CYC > 0) begin : g_late_drive
      AST_DRV_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> !mem_dq_oe); // R5
    end
  endgenerate

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 4,
  parameter int CLK_NS   = 10,
  parameter int T_AA_NS  = 20,
  parameter int T_AC_NS  = 20,
  parameter int T_WP_NS  = 15,
  parameter int T_AW_NS  = 15,
  parameter int T_CW_NS  = 15,
  parameter int T_WC_NS  = 20,
  parameter int T_DW_NS  = 8,
  parameter int T_WZ_NS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  // Cycle counts derived from the timing parameters
  localparam int RD_CYC  = int'(max2(1, ns_to_cyc(max2(T_AA_NS, T_AC_NS), CLK_NS)));
  localparam int WZ_CYC  = int'(ns_to_cyc(T_WZ_NS, CLK_NS));
  localparam int DW_CYC  = int'(max2(1, ns_to_cyc(T_DW_NS, CLK_NS)));
  localparam int WP_CYC  = int'(ns_to_cyc(T_WP_NS, CLK_NS));
  localparam int AW_STB  = int'(ns_to_cyc(T_AW_NS, CLK_NS)) - 1;
  localparam int CW_STB  = int'(ns_to_cyc(T_CW_NS, CLK_NS)) - 1;
  localparam int WC_STB  = int'(ns_to_cyc(T_WC_NS, CLK_NS)) - 1;
  localparam int STB_A   = int'(max2(max2(1, WP_CYC), max2(AW_STB, CW_STB)));
  localparam int STB_CYC = int'(max2(max2(STB_A, WC_STB), WZ_CYC + DW_CYC));
  localparam int CNT_W   = $clog2(int'(max2(RD_CYC, STB_CYC)) + 1);

  logic             rst_meta, rst_sync;
  logic             tmr_load, tmr_zero, capture;
  logic [CNT_W-1:0] tmr_val, tmr_cnt;

  // Reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync),
    .load     (tmr_load),
    .load_val (tmr_val),
    .cnt      (tmr_cnt),
    .zero     (tmr_zero)
  );

  sram_seq #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .RD_CYC  (RD_CYC),
    .STB_CYC (STB_CYC),
    .WZ_CYC  (WZ_CYC),
    .CNT_W   (CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_ready  (req_ready),
    .tmr_cnt    (tmr_cnt),
    .tmr_zero   (tmr_zero),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .capture    (capture),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_sync),
    .capture  (capture),
    .dq_in    (mem_dq_in),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  AST_RD_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_sync)
    (!mem_ce_n && mem_we_n) |-> !mem_dq_oe); // R8
  AST_RDV_IN_STANDBY: assert property (@(posedge clk) disable iff (!rst_sync)
    rd_valid |-> mem_ce_n); // R8

endmodule

// File: tb/sim_sram_ctrl.sv
module sim_sram_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int RD_CYC     = 2;
  localparam int STB_CYC    = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_ready, rd_valid;
  logic [15:0] req_addr, mem_addr;
  logic [3:0]  req_wdata, rd_data, mem_dq_out;
  logic [3:0]  mem_dq_in = 4'h0;
  logic        mem_ce_n, mem_we_n, mem_dq_oe;

  int   checks = 0;
  int   errors = 0;
  int   cyc    = 0;
  bit   mon_en = 1'b0;
  bit   done   = 1'b0;

  logic [3:0] gold [int];
  logic [3:0] mm   [int];
  logic [3:0] exp_wdata;

  sram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] init_val(input logic [15:0] a);
    return a[3:0] ^ a[7:4] ^ a[15:12] ^ 4'h5;
  endfunction

  function automatic logic [3:0] gold_rd(input logic [15:0] a);
    return gold.exists(int'(a)) ? gold[int'(a)] : init_val(a);
  endfunction

  function automatic logic [3:0] mm_rd(input logic [15:0] a);
    return mm.exists(int'(a)) ? mm[int'(a)] : init_val(a);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Memory model and strobe monitor, sampled on the falling edge
  logic        prev_rd = 1'b0, prev_we = 1'b1, prev_ce = 1'b1;
  logic [15:0] prev_addr = '0, waddr = '0;
  logic [3:0]  wseen = '0;
  int          age = 0, wcnt = 0;

  always @(negedge clk) begin
    if (mon_en) begin
      if (!mem_ce_n && mem_we_n && prev_rd && mem_addr == prev_addr) age++;
      else age = 0;
      // Data only becomes correct once the access time has passed
      mem_dq_in = (age >= RD_CYC - 1) ? mm_rd(mem_addr) : ~mm_rd(mem_addr);
      if (mem_ce_n) check(mem_we_n && !mem_dq_oe, "R2 standby quiet", {mem_we_n, mem_dq_oe}, 2);
      if (!mem_ce_n && mem_we_n) check(!mem_dq_oe, "R8 no drive in read mode", mem_dq_oe, 0);
      if (mem_dq_oe) check(!mem_we_n && !mem_ce_n, "R5 drive only in strobe", {mem_ce_n, mem_we_n}, 0);
      if (!mem_we_n) begin
        if (prev_we) begin
          wcnt  = 1;
          waddr = mem_addr;
          check(prev_ce == 1'b0, "R4 setup cycle before strobe", prev_ce, 0);
          check(!mem_dq_oe, "R5 driver off in first strobe cycle", mem_dq_oe, 0);
        end else begin
          wcnt++;
          check(mem_addr == waddr, "R3 address held in strobe", mem_addr, waddr);
        end
        if (mem_dq_oe) wseen = mem_dq_out;
      end else if (!prev_we) begin
        check(wcnt == STB_CYC, "R4 strobe length", wcnt, STB_CYC);
        check(mem_ce_n, "R4 strobes rise together", mem_ce_n, 1);
        check(mem_addr == waddr, "R3 address held after strobe", mem_addr, waddr);
        check(!mem_dq_oe, "R6 driver released with strobe", mem_dq_oe, 0);
        check(wseen == exp_wdata, "R6 driven nibble", wseen, exp_wdata);
        mm[int'(waddr)] = wseen;
      end
      prev_rd   = !mem_ce_n && mem_we_n;
      prev_we   = mem_we_n;
      prev_ce   = mem_ce_n;
      prev_addr = mem_addr;
    end
  end

  task automatic offer(input logic wr, input logic [15:0] a, input logic [3:0] d);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = $urandom;
    req_wdata = $urandom;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [3:0] d);
    int n;
    exp_wdata = d;
    gold[int'(a)] = d;
    offer(1'b1, a, d);
    n = 1;
    while (!req_ready && n < 20) begin
      @(negedge clk);
      n++;
    end
    check(n == STB_CYC + 3, "R9 ready after write", n, STB_CYC + 3);
  endtask

  task automatic do_read(input logic [15:0] a);
    int n;
    logic [3:0] e;
    e = gold_rd(a);
    offer(1'b0, a, 4'h0);
    n = 1;
    while (!rd_valid && n < 20) begin
      check(!req_ready, "R9 ready low during read", req_ready, 0);
      @(negedge clk);
      n++;
    end
    check(n == RD_CYC + 1, "R7 read latency", n, RD_CYC + 1);
    check(rd_data == e, "R10 read data", rd_data, e);
    check(mem_ce_n, "R8 idle cycle after read", mem_ce_n, 1);
    @(negedge clk);
    check(!rd_valid, "R7 rd_valid single pulse", rd_valid, 0);
    check(req_ready, "R9 ready after read", req_ready, 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    exp_wdata = '0;
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_we_n && !mem_dq_oe && !rd_valid, "R1 standby in reset",
          {mem_ce_n, mem_we_n, mem_dq_oe, rd_valid}, 4'b1100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(mem_ce_n && mem_we_n && !mem_dq_oe && !rd_valid, "R1 standby after reset",
          {mem_ce_n, mem_we_n, mem_dq_oe, rd_valid}, 4'b1100);
    check(req_ready, "R1 ready after reset", req_ready, 1);
    mon_en = 1'b1;

    // Directed corner cases
    do_read(16'h0000);
    do_write(16'h0000, 4'hF);
    do_read(16'h0000);
    do_write(16'hFFFF, 4'h0);
    do_read(16'hFFFF);
    do_read(16'h1234);
    do_write(16'h1234, 4'hA);
    do_write(16'h1234, 4'h5);
    do_read(16'h1234);
    do_write(16'h8001, 4'h3);
    do_write(16'h8002, 4'hC);
    do_read(16'h8001);
    do_read(16'h8002);
    repeat (5) @(negedge clk);
    check(mem_ce_n && !mem_dq_oe, "R2 standby when no request", {mem_ce_n, mem_dq_oe}, 2);

    // Random traffic on a small address window
    void'($urandom(32'd20240917));
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      a = 16'($urandom_range(0, 15));
      if ($urandom_range(0, 3) == 0) a = a | 16'hFFF0;
      if ($urandom_range(0, 1) == 1) do_write(a, 4'($urandom));
      else do_read(a);
      if ($urandom_range(0, 4) == 0) repeat ($urandom_range(1, 3)) @(negedge clk);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule